// File: doc/BRIEF.md
# Bit-band alias bridge

This bridge sits between a requester and a byte-addressed backing memory and gives every bit of two backing regions its own 32-bit alias word. A requester reading an alias word gets the addressed backing bit back in bit 0. A requester writing an alias word changes that one backing bit and leaves every other backing bit as it was. The bridge does this with a read of the backing memory, followed for writes by a write of the same bytes with the one bit merged in.

The requester side and the backing side each use a valid/ready request handshake. Responses are a single-cycle valid pulse with data and an error flag. Only one transaction is in flight at a time. The request side is held off from acceptance until the response cycle ends, so nothing can slip in between the read and the write of a read-modify-write. Unsupported sizes, addresses outside both alias windows, and requests made while the windows are switched off are answered with an error and never reach the backing memory. An error reported by the backing memory at either step is passed back to the requester.

Top module: `bitband_bridge`

## Requirements
- R1: An address in [0x2200_0000, 0x23FF_FFFF] uses backing base 0x2000_0000, and an address in [0x4200_0000, 0x43FF_FFFF] uses backing base 0x4000_0000. Any other address is answered with s_rerr=1 and causes no backing access.
- R2: The backing byte address is the backing base OR'ed with the 25-bit window offset shifted right by 5, then cleared in its low bits to a multiple of the size. m_size equals the request size (1, 2 or 4, in bytes).
- R3: The selected bit is bit ((offset >> 2) & (8*size-1)) of the backing data. Backing data is right-justified on m_rdata/m_wdata, with the byte at the lowest address in bits 7:0.
- R4: A read answers with the selected bit in s_rdata[0], s_rdata[31:1]=0 and s_rerr=0.
- R5: A write reads size bytes, then writes the same address and size with only the selected bit replaced by s_wdata[0]. s_wdata[31:1] has no effect. The response carries s_rerr=0 and s_rdata=0.
- R6: If the backing read reports m_err=1, no backing write is issued and the response has s_rerr=1.
- R7: If the backing write reports m_err=1, the response has s_rerr=1.
- R8: A size of 0, 3 or above 4 is answered in the cycle after acceptance with s_rerr=1, and causes no backing access.
- R9: With win_en=0, every request is answered with s_rerr=1 and causes no backing access.
- R10: After reset s_ready=1, s_rvalid=0 and m_valid=0. s_ready is low from acceptance through the response cycle. A backing request that is not yet accepted holds its address, direction and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_en | input | 1 | Enables both alias windows |
| s_valid | input | 1 | Requester request valid |
| s_ready | output | 1 | Bridge can accept a request |
| s_addr | input | 32 | Requester alias address |
| s_write | input | 1 | 1 = write, 0 = read |
| s_size | input | 3 | Access size in bytes |
| s_wdata | input | 32 | Write data, bit 0 is the new bit value |
| s_rvalid | output | 1 | Response valid, one cycle |
| s_rdata | output | 32 | Read bit in bit 0 |
| s_rerr | output | 1 | Response error |
| m_valid | output | 1 | Backing request valid |
| m_ready | input | 1 | Backing memory accepts the request |
| m_addr | output | 32 | Backing byte address |
| m_write | output | 1 | Backing request is a write |
| m_size | output | 3 | Backing access size in bytes |
| m_wdata | output | 32 | Backing write data, right-justified |
| m_rvalid | input | 1 | Backing response valid |
| m_rdata | input | 32 | Backing read data, right-justified |
| m_err | input | 1 | Backing response error |

## Verification
The bench builds the bridge with its default parameters: two windows 32 MiB wide at the standard alias and backing bases. With these, both windows are exercised, and so are offsets at the very top of a window and addresses just outside one. The bench's backing-memory model can stall its ready signal and can inject an error on a chosen address for reads or for writes. That reaches the read-error abort, the write-error pass-through, and held backing requests under back-pressure, for all three legal sizes.

// File: rtl/bb_pkg.sv
package bb_pkg;

    localparam int unsigned BB_AW         = 32;
    localparam int unsigned BB_DW         = 32;
    localparam int unsigned BB_SZW        = 3;
    localparam int unsigned BB_IDXW       = $clog2(BB_DW);
    // one alias word is 4 bytes, one backing byte holds 8 bits
    localparam int unsigned BB_WORD_SHIFT = 2;
    localparam int unsigned BB_BIT_SHIFT  = 3;
    localparam int unsigned BB_ADDR_SHIFT = BB_WORD_SHIFT + BB_BIT_SHIFT;

    typedef logic [BB_AW-1:0]   addr_t;
    typedef logic [BB_DW-1:0]   data_t;
    typedef logic [BB_SZW-1:0]  size_t;
    typedef logic [BB_IDXW-1:0] idx_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ,
        ST_WR_WAIT,
        ST_RESP
    } st_e;

    typedef struct packed {
        logic  hit;
        addr_t baddr;
        idx_t  idx;
    } xlate_t;

    typedef struct packed {
        logic   wr;
        logic   wbit;
        size_t  size;
        xlate_t xl;
    } job_t;

    function automatic logic size_legal(size_t sz);
        return (sz == size_t'(1)) || (sz == size_t'(2)) || (sz == size_t'(4));
    endfunction

    function automatic addr_t size_floor(addr_t a, size_t sz);
        addr_t low;
        low = addr_t'(sz) - addr_t'(1);
        return a & ~low;
    endfunction

    function automatic idx_t bit_pick(addr_t off, size_t sz);
        addr_t lim;
        lim = (addr_t'(sz) << BB_BIT_SHIFT) - addr_t'(1);
        return idx_t'((off >> BB_WORD_SHIFT) & lim);
    endfunction

endpackage

// File: rtl/bb_xlate.sv
module bb_xlate
    import bb_pkg::*;
#(
    parameter int unsigned             NUM_WIN     = 2,
    parameter int unsigned             WIN_LOG2    = 25,
    parameter logic [NUM_WIN*BB_AW-1:0] ALIAS_BASES = {32'h4200_0000, 32'h2200_0000},
    parameter logic [NUM_WIN*BB_AW-1:0] BACK_BASES  = {32'h4000_0000, 32'h2000_0000}
) (
    input  addr_t  addr,
    input  size_t  size,
    output xlate_t xl
);

    localparam addr_t OFF_MASK = addr_t'((64'd1 << WIN_LOG2) - 64'd1);

    logic  [NUM_WIN-1:0] hit_v;
    addr_t [NUM_WIN-1:0] raw_v;
    addr_t               off;

    assign off = addr & OFF_MASK;

    // R1 / R2: per-window match and raw backing byte address
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        localparam addr_t ABASE = ALIAS_BASES[w*BB_AW +: BB_AW];
        localparam addr_t BBASE = BACK_BASES[w*BB_AW +: BB_AW];
        assign hit_v[w] = (addr & ~OFF_MASK) == ABASE;
        assign raw_v[w] = BBASE | (off >> BB_ADDR_SHIFT);
    end

    addr_t raw_sel;

    always_comb begin
        raw_sel = '0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (hit_v[w]) raw_sel = raw_v[w];
        end
        xl.hit   = |hit_v;
        xl.baddr = size_floor(raw_sel, size);   // R2
        xl.idx   = bit_pick(off, size);         // R3
    end

endmodule

// File: rtl/bb_lane.sv
module bb_lane
    import bb_pkg::*;
(
    input  data_t rdata,
    input  idx_t  idx,
    input  logic  wbit,
    output logic  bit_out,
    output data_t merged
);

    // R3 / R5: pick one bit, or replace it and keep the rest
    always_comb begin
        bit_out = rdata[idx];
        merged  = rdata;
        merged[idx] = wbit;
    end

endmodule

// File: rtl/bb_seq.sv
module bb_seq
    import bb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   win_en,
    input  logic   s_valid,
    input  logic   s_write,
    input  size_t  s_size,
    input  logic   s_wbit,
    input  xlate_t xl_in,
    output logic   s_ready,
    output logic   s_rvalid,
    output logic   s_rbit,
    output logic   s_rerr,
    output logic   m_valid,
    input  logic   m_ready,
    output addr_t  m_addr,
    output logic   m_write,
    output size_t  m_size,
    output data_t  m_wdata,
    input  logic   m_rvalid,
    input  logic   m_err,
    input  logic   lane_bit,
    input  data_t  lane_merged,
    output idx_t   job_idx,
    output logic   job_wbit
);

    st_e   st_q;
    job_t  job_q;
    data_t wdata_q;
    logic  rbit_q;
    logic  rerr_q;
    logic  reject;

    // R1 / R8 / R9: refusal decided on the incoming request
    assign reject = !win_en || !xl_in.hit || !size_legal(s_size);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            job_q   <= '0;
            wdata_q <= '0;
            rbit_q  <= 1'b0;
            rerr_q  <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (s_valid) begin
                        job_q  <= '{wr: s_write, wbit: s_wbit, size: s_size, xl: xl_in};
                        rbit_q <= 1'b0;
                        rerr_q <= reject;
                        st_q   <= reject ? ST_RESP : ST_RD_REQ;
                    end
                end
                ST_RD_REQ: begin
                    if (m_ready) st_q <= ST_RD_WAIT;
                end
                ST_RD_WAIT: begin
                    if (m_rvalid) begin
                        if (m_err) begin              // R6
                            rerr_q <= 1'b1;
                            st_q   <= ST_RESP;
                        end else if (job_q.wr) begin  // R5
                            wdata_q <= lane_merged;
                            st_q    <= ST_WR_REQ;
                        end else begin                // R4
                            rbit_q <= lane_bit;
                            st_q   <= ST_RESP;
                        end
                    end
                end
                ST_WR_REQ: begin
                    if (m_ready) st_q <= ST_WR_WAIT;
                end
                ST_WR_WAIT: begin
                    if (m_rvalid) begin               // R7
                        rerr_q <= m_err;
                        st_q   <= ST_RESP;
                    end
                end
                ST_RESP: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign s_ready  = (st_q == ST_IDLE);
    assign s_rvalid = (st_q == ST_RESP);
    assign s_rbit   = rbit_q;
    assign s_rerr   = rerr_q;
    assign m_valid  = (st_q == ST_RD_REQ) || (st_q == ST_WR_REQ);
    assign m_write  = (st_q == ST_WR_REQ);
    assign m_addr   = job_q.xl.baddr;
    assign m_size   = job_q.size;
    assign m_wdata  = wdata_q;
    assign job_idx  = job_q.xl.idx;
    assign job_wbit = job_q.wbit;

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
    import bb_pkg::*;
#(
    parameter int unsigned             NUM_WIN     = 2,
    parameter int unsigned             WIN_LOG2    = 25,
    parameter logic [NUM_WIN*BB_AW-1:0] ALIAS_BASES = {32'h4200_0000, 32'h2200_0000},
    parameter logic [NUM_WIN*BB_AW-1:0] BACK_BASES  = {32'h4000_0000, 32'h2000_0000}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              win_en,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [BB_AW-1:0]  s_addr,
    input  logic              s_write,
    input  logic [BB_SZW-1:0] s_size,
    input  logic [BB_DW-1:0]  s_wdata,
    output logic              s_rvalid,
    output logic [BB_DW-1:0]  s_rdata,
    output logic              s_rerr,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [BB_AW-1:0]  m_addr,
    output logic              m_write,
    output logic [BB_SZW-1:0] m_size,
    output logic [BB_DW-1:0]  m_wdata,
    input  logic              m_rvalid,
    input  logic [BB_DW-1:0]  m_rdata,
    input  logic              m_err
);

    xlate_t xl;
    idx_t   job_idx;
    logic   job_wbit;
    logic   lane_bit;
    data_t  lane_merged;
    logic   rbit;
    logic   unused_wdata_hi;

    // R5: only bit 0 of the write data carries meaning
    assign unused_wdata_hi = ^s_wdata[BB_DW-1:1];

    bb_xlate #(
        .NUM_WIN     (NUM_WIN),
        .WIN_LOG2    (WIN_LOG2),
        .ALIAS_BASES (ALIAS_BASES),
        .BACK_BASES  (BACK_BASES)
    ) u_xlate (
        .addr (s_addr),
        .size (s_size),
        .xl   (xl)
    );

    bb_lane u_lane (
        .rdata   (m_rdata),
        .idx     (job_idx),
        .wbit    (job_wbit),
        .bit_out (lane_bit),
        .merged  (lane_merged)
    );

    bb_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .win_en      (win_en),
        .s_valid     (s_valid),
        .s_write     (s_write),
        .s_size      (s_size),
        .s_wbit      (s_wdata[0]),
        .xl_in       (xl),
        .s_ready     (s_ready),
        .s_rvalid    (s_rvalid),
        .s_rbit      (rbit),
        .s_rerr      (s_rerr),
        .m_valid     (m_valid),
        .m_ready     (m_ready),
        .m_addr      (m_addr),
        .m_write     (m_write),
        .m_size      (m_size),
        .m_wdata     (m_wdata),
        .m_rvalid    (m_rvalid),
        .m_err       (m_err),
        .lane_bit    (lane_bit),
        .lane_merged (lane_merged),
        .job_idx     (job_idx),
        .job_wbit    (job_wbit)
    );

    assign s_rdata = {{(BB_DW-1){1'b0}}, rbit};   // R4

endmodule

// File: rtl/bb_checker.sv
module bb_checker
    import bb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              win_en,
    input logic              s_valid,
    input logic              s_ready,
    input logic [BB_SZW-1:0] s_size,
    input logic              s_rvalid,
    input logic [BB_DW-1:0]  s_rdata,
    input logic              s_rerr,
    input logic              m_valid,
    input logic              m_ready,
    input logic [BB_AW-1:0]  m_addr,
    input logic              m_write,
    input logic [BB_SZW-1:0] m_size,
    input logic [BB_DW-1:0]  m_wdata,
    input logic              m_rvalid,
    input logic [BB_DW-1:0]  m_rdata,
    input logic              m_err
);

    logic [BB_SZW-1:0] cap_size;
    logic              ph_wr;
    logic [BB_DW-1:0]  cap_rd;
    logic              bad_size;

    assign bad_size = !((s_size == 3'd1) || (s_size == 3'd2) || (s_size == 3'd4));

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_size <= '0;
            ph_wr    <= 1'b0;
            cap_rd   <= '0;
        end else begin
            if (s_valid && s_ready) cap_size <= s_size;
            if (m_valid && m_ready) ph_wr <= m_write;
            if (m_rvalid && !ph_wr) cap_rd <= m_rdata;
        end
    end

    AST_BAD_SIZE_ERR: assert property (@(posedge clk) disable iff (rst)
        s_valid && s_ready && bad_size |=> s_rvalid && s_rerr && !m_valid); // R8
    AST_WIN_OFF_ERR: assert property (@(posedge clk) disable iff (rst)
        s_valid && s_ready && !win_en |=> s_rvalid && s_rerr && !m_valid); // R9
    AST_BACK_ERR_STOPS: assert property (@(posedge clk) disable iff (rst)
        m_rvalid && m_err |=> s_rvalid && s_rerr && !m_valid); // R6
    AST_RDATA_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        s_rvalid |-> s_rdata[BB_DW-1:1] == '0); // R4
    AST_SIZE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        m_valid |-> (m_addr & (BB_AW'(m_size) - BB_AW'(1))) == '0); // R2
    AST_SIZE_MATCH: assert property (@(posedge clk) disable iff (rst)
        m_valid |-> m_size == cap_size); // R2
    AST_WRITE_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        m_valid && m_write |-> $countones(m_wdata ^ cap_rd) <= 1); // R5
    AST_MREQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        m_valid && !m_ready |=> m_valid && $stable(m_addr) && $stable(m_write) && $stable(m_wdata)); // R10
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (s_rvalid || m_valid) |-> !s_ready); // R10

endmodule

bind bitband_bridge bb_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .win_en   (win_en),
    .s_valid  (s_valid),
    .s_ready  (s_ready),
    .s_size   (s_size),
    .s_rvalid (s_rvalid),
    .s_rdata  (s_rdata),
    .s_rerr   (s_rerr),
    .m_valid  (m_valid),
    .m_ready  (m_ready),
    .m_addr   (m_addr),
    .m_write  (m_write),
    .m_size   (m_size),
    .m_wdata  (m_wdata),
    .m_rvalid (m_rvalid),
    .m_rdata  (m_rdata),
    .m_err    (m_err)
);

// File: tb/bitband_bridge_tb_top.sv
module bitband_bridge_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        win_en = 1'b1;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [31:0] s_addr = '0;
    logic        s_write = 1'b0;
    logic [2:0]  s_size = 3'd1;
    logic [31:0] s_wdata = '0;
    logic        s_rvalid;
    logic [31:0] s_rdata;
    logic        s_rerr;
    logic        m_valid;
    logic        m_ready = 1'b1;
    logic [31:0] m_addr;
    logic        m_write;
    logic [2:0]  m_size;
    logic [31:0] m_wdata;
    logic        m_rvalid = 1'b0;
    logic [31:0] m_rdata = '0;
    logic        m_err = 1'b0;

    always #5 clk = ~clk;   // 100 MHz

    bitband_bridge dut_i (
        .clk(clk), .rst(rst), .win_en(win_en),
        .s_valid(s_valid), .s_ready(s_ready), .s_addr(s_addr), .s_write(s_write),
        .s_size(s_size), .s_wdata(s_wdata), .s_rvalid(s_rvalid), .s_rdata(s_rdata),
        .s_rerr(s_rerr), .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr),
        .m_write(m_write), .m_size(m_size), .m_wdata(m_wdata), .m_rvalid(m_rvalid),
        .m_rdata(m_rdata), .m_err(m_err)
    );

    int errs = 0;
    int checks = 0;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---------------- backing memory model ----------------
    logic [7:0]  mem [logic [31:0]];
    int          n_rd = 0, n_wr = 0;
    logic [31:0] last_addr = '0;
    logic [2:0]  last_size = '0;
    logic [31:0] err_rd_addr = 32'hFFFF_FFFF;
    logic [31:0] err_wr_addr = 32'hFFFF_FFFF;
    bit          stall_en = 0;
    bit          pend = 0;
    logic [31:0] pend_data = '0;
    logic        pend_err = 1'b0;
    int          cyc = 0;

    function automatic logic [7:0] rd_byte(logic [31:0] a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    always @(negedge clk) begin
        cyc++;
        m_rvalid = 1'b0;
        m_err    = 1'b0;
        if (rst) begin
            pend = 0;
            m_ready = 1'b1;
        end else begin
            if (pend) begin
                m_rvalid = 1'b1;
                m_rdata  = pend_data;
                m_err    = pend_err;
                pend     = 0;
            end
            m_ready = stall_en ? ((cyc % 3) == 0) : 1'b1;
            if (m_valid && m_ready) begin
                last_addr = m_addr;
                last_size = m_size;
                pend_data = '0;
                if (m_write) begin
                    n_wr++;
                    pend_err = (m_addr == err_wr_addr);
                    if (!pend_err)
                        for (int i = 0; i < int'(m_size); i++) mem[m_addr + i] = m_wdata[8*i +: 8];
                end else begin
                    n_rd++;
                    pend_err = (m_addr == err_rd_addr);
                    for (int i = 0; i < int'(m_size); i++) pend_data[8*i +: 8] = rd_byte(m_addr + i);
                end
                pend = 1;
            end
        end
    end

    // ---------------- scoreboard ----------------
    logic [31:0] exp_d[$];
    logic        exp_e[$];
    string       exp_r[$];

    always @(negedge clk) begin
        if (!rst && s_rvalid) begin
            if (exp_d.size() == 0) begin
                chk("R10", "unexpected response", 32'd1, 32'd0);
            end else begin
                logic [31:0] d;
                logic        e;
                string       r;
                d = exp_d.pop_front();
                e = exp_e.pop_front();
                r = exp_r.pop_front();
                chk(r, "response data", s_rdata, d);
                chk(r, "response error", {31'b0, s_rerr}, {31'b0, e});
            end
        end
    end

    task automatic do_req(logic [31:0] addr, logic wr, logic [2:0] size, logic [31:0] wdata,
                          logic [31:0] ed, logic ee, string req);
        exp_d.push_back(ed);
        exp_e.push_back(ee);
        exp_r.push_back(req);
        @(negedge clk);
        s_valid = 1'b1; s_addr = addr; s_write = wr; s_size = size; s_wdata = wdata;
        while (!s_ready) @(negedge clk);
        @(negedge clk);
        s_valid = 1'b0;
        chk("R10", "ready low while busy", {31'b0, s_ready}, 32'd0);
        while (exp_d.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL R10 watchdog actual=hung expected=done");
        summary();
    end

    int rd0, wr0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10", "reset s_ready", {31'b0, s_ready}, 32'd1);
        chk("R10", "reset s_rvalid", {31'b0, s_rvalid}, 32'd0);
        chk("R10", "reset m_valid", {31'b0, m_valid}, 32'd0);

        mem[32'h2000_0010] = 8'hA5;
        mem[32'h2000_0011] = 8'h3C;
        mem[32'h2000_0013] = 8'h80;
        mem[32'h4000_0100] = 8'h01;
        mem[32'h200F_FFFF] = 8'h80;

        // R1 R3 R4: byte reads in window 0, bits of 0xA5
        for (int b = 0; b < 8; b++)
            do_req(32'h2200_0000 | (32'h10 << 5) | (b << 2), 0, 3'd1, 0, (8'hA5 >> b) & 1, 0, "R4");
        chk("R2", "byte read address", last_addr, 32'h2000_0010);
        chk("R2", "byte read size", {29'b0, last_size}, 32'd1);

        // R2 R3: halfword, byte 0x11 is lane 1
        do_req(32'h2200_0000 | (32'h11 << 5) | (2 << 2), 0, 3'd2, 0, 1, 0, "R3");
        chk("R2", "halfword aligned address", last_addr, 32'h2000_0010);
        do_req(32'h2200_0000 | (32'h11 << 5) | (0 << 2), 0, 3'd2, 0, 0, 0, "R3");
        // word, byte 0x13 is lane 3
        do_req(32'h2200_0000 | (32'h13 << 5) | (7 << 2), 0, 3'd4, 0, 1, 0, "R3");
        chk("R2", "word aligned address", last_addr, 32'h2000_0010);
        chk("R2", "word size", {29'b0, last_size}, 32'd4);

        // R1: second window
        do_req(32'h4200_2000, 0, 3'd4, 0, 1, 0, "R1");
        chk("R1", "window 1 address", last_addr, 32'h4000_0100);
        // R2: top of window 0
        do_req(32'h23FF_FFFC, 0, 3'd1, 0, 1, 0, "R2");
        chk("R2", "top of window address", last_addr, 32'h200F_FFFF);

        // R5: byte writes, set then clear with upper data bits high
        mem[32'h2000_0020] = 8'h0F;
        rd0 = n_rd; wr0 = n_wr;
        do_req(32'h2200_0000 | (32'h20 << 5) | (6 << 2), 1, 3'd1, 32'h0000_0001, 0, 0, "R5");
        chk("R5", "set bit", {24'b0, rd_byte(32'h2000_0020)}, 32'h4F);
        chk("R5", "one read one write", (n_rd - rd0) * 16 + (n_wr - wr0), 32'h11);
        do_req(32'h2200_0000 | (32'h20 << 5) | (1 << 2), 1, 3'd1, 32'hFFFF_FFFE, 0, 0, "R5");
        chk("R5", "clear bit, upper data ignored", {24'b0, rd_byte(32'h2000_0020)}, 32'h4D);

        // R5: word write, only lane 2 bit 2 changes
        mem[32'h2000_0030] = 8'h11; mem[32'h2000_0031] = 8'h22;
        mem[32'h2000_0032] = 8'h33; mem[32'h2000_0033] = 8'h44;
        do_req(32'h2200_0000 | (32'h32 << 5) | (2 << 2), 1, 3'd4, 32'h1, 0, 0, "R5");
        chk("R5", "word write address", last_addr, 32'h2000_0030);
        chk("R5", "word write bytes",
            {rd_byte(32'h2000_0033), rd_byte(32'h2000_0032), rd_byte(32'h2000_0031), rd_byte(32'h2000_0030)},
            32'h4437_2211);

        // R8: illegal sizes
        rd0 = n_rd; wr0 = n_wr;
        do_req(32'h2200_0000, 0, 3'd3, 0, 0, 1, "R8");
        do_req(32'h2200_0000, 1, 3'd0, 1, 0, 1, "R8");
        do_req(32'h2200_0000, 0, 3'd5, 0, 0, 1, "R8");
        chk("R8", "no backing access", (n_rd - rd0) + (n_wr - wr0), 0);

        // R1: outside both windows
        do_req(32'h2400_0000, 0, 3'd1, 0, 0, 1, "R1");
        do_req(32'h21FF_FFFC, 1, 3'd1, 1, 0, 1, "R1");
        chk("R1", "no access outside windows", (n_rd - rd0) + (n_wr - wr0), 0);

        // R9: windows disabled
        win_en = 1'b0;
        do_req(32'h2200_0200, 0, 3'd1, 0, 0, 1, "R9");
        do_req(32'h4200_0000, 1, 3'd4, 1, 0, 1, "R9");
        chk("R9", "no access when disabled", (n_rd - rd0) + (n_wr - wr0), 0);
        win_en = 1'b1;

        // R6: read error aborts a write
        mem[32'h2000_0040] = 8'h00;
        err_rd_addr = 32'h2000_0040;
        rd0 = n_rd; wr0 = n_wr;
        do_req(32'h2200_0000 | (32'h40 << 5), 1, 3'd1, 1, 0, 1, "R6");
        chk("R6", "no write after read error", n_wr - wr0, 0);
        chk("R6", "memory untouched", {24'b0, rd_byte(32'h2000_0040)}, 0);
        err_rd_addr = 32'hFFFF_FFFF;

        // R7: write error returned
        err_wr_addr = 32'h2000_0050;
        wr0 = n_wr;
        do_req(32'h2200_0000 | (32'h50 << 5), 1, 3'd1, 1, 0, 1, "R7");
        chk("R7", "write was issued", n_wr - wr0, 1);
        err_wr_addr = 32'hFFFF_FFFF;

        // R10: back-pressure on the backing side
        stall_en = 1;
        mem[32'h2000_0060] = 8'h00;
        do_req(32'h2200_0000 | (32'h60 << 5) | (3 << 2), 1, 3'd2, 1, 0, 0, "R10");
        chk("R10", "stalled write result", {24'b0, rd_byte(32'h2000_0060)}, 32'h08);
        do_req(32'h2200_0000 | (32'h60 << 5) | (3 << 2), 0, 3'd2, 0, 1, 0, "R10");
        do_req(32'h4200_2000, 0, 3'd1, 0, 1, 0, "R10");
        stall_en = 0;

        repeat (3) @(negedge clk);
        summary();
    end

endmodule